// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Responder

This block serves the memory end of a split-transaction interconnect. A requester sends one request that holds the whole atomic operation: a target address, a 3-bit operation code, up to two data operands and a requester tag. The block then runs an indivisible read-modify-write on a local single-port synchronous memory. It sends the word it found back later, on a separate response channel, together with the same tag. No lock on the bus or on the responder is held between a read and a write.

Requests come in on a valid/ready channel and responses go out on a second valid/ready channel. Only one operation is in progress at a time. The request side stays not-ready from acceptance until its response has been taken. The memory read and the write that depends on it happen in back-to-back cycles, and nothing can reach the memory between them.

Top module: `atomic_responder`

## Requirements
- R1: After reset `req_ready` is high and `rsp_valid` is low. From the cycle after a request is accepted (`req_valid` and `req_ready` both high at a clock edge) `req_ready` stays low until the response handshake completes. A request offered during that time is not taken and has no effect on memory.
- R2: `req_op` encoding: 3'b000 probe, 3'b001 exchange, 3'b010 compare-exchange, 3'b011 fetch-add. Any code with bit 2 set is reserved.
- R3: Exchange returns the word held at `req_addr` before the operation and stores `req_opa` there.
- R4: Fetch-add returns the original word and stores (original + `req_opa`) mod 2^DATA_W there. There is no overflow indication.
- R5: Compare-exchange returns the original word. It stores `req_opb` only when the original equals `req_opa`. `rsp_match` is 1 exactly when they were equal.
- R6: A probe writes nothing and returns `rsp_data` = 0 with `rsp_err` = 0.
- R7: A reserved code returns `rsp_err` = 1 and `rsp_data` = 0, and leaves memory unchanged.
- R8: `rsp_tag` equals the `req_tag` of the request the response answers. `rsp_match` is 0 for every operation other than compare-exchange.
- R9: The memory read and any write of one operation go to the same address in consecutive cycles. No other memory access happens between them.
- R10: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_data`, `rsp_tag`, `rsp_err` and `rsp_match` hold steady.
- R11: `rsp_valid` rises two clock edges after acceptance for exchange, compare-exchange and fetch-add. It rises one edge after acceptance for probe and reserved codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Target word address |
| req_op | input | 3 | Operation code |
| req_opa | input | DATA_W | Exchange data, addend, or compare value |
| req_opb | input | DATA_W | Replacement value for compare-exchange |
| req_tag | input | TAG_W | Requester identifier |
| rsp_valid | output | 1 | Response offered |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | DATA_W | Original memory word, or 0 |
| rsp_tag | output | TAG_W | Echoed requester identifier |
| rsp_err | output | 1 | Reserved operation code seen |
| rsp_match | output | 1 | Compare-exchange comparison matched |

## Verification
The hardest case to reach from the ports is a second request that arrives while a finished result sits unclaimed on the response side. The block must refuse that request, and it must not let the request touch memory behind the held response. The bench reaches this case by holding `rsp_ready` low and presenting a conflicting exchange to the same address for several cycles. It then releases the response and reads the word back with a further exchange, which shows the intruder never landed. The other hard cases are a compare-exchange miss and a reserved code, which must leave memory alone. Each is followed by an exchange at the same address, so the unchanged word becomes visible on `rsp_data`.

// File: rtl/atom_pkg.sv
package atom_pkg;

    localparam int OP_W = 3;

    localparam logic [OP_W-1:0] OP_PROBE = 3'b000;
    localparam logic [OP_W-1:0] OP_XCHG  = 3'b001;
    localparam logic [OP_W-1:0] OP_CXCHG = 3'b010;
    localparam logic [OP_W-1:0] OP_FADD  = 3'b011;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_MODIFY = 2'd1,
        PH_RESP   = 2'd2
    } phase_e;

    function automatic logic op_reserved(input logic [OP_W-1:0] op);
        return op[OP_W-1];
    endfunction

    function automatic logic op_needs_mem(input logic [OP_W-1:0] op);
        return (op == OP_XCHG) || (op == OP_CXCHG) || (op == OP_FADD);
    endfunction

endpackage

// File: rtl/atom_mem.sv
module atom_mem #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                store[addr] <= wdata;
            end
            rdata <= store[addr];
        end
    end
endmodule

// File: rtl/atom_alu.sv
module atom_alu
    import atom_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [OP_W-1:0]   op,
    input  logic [DATA_W-1:0] orig,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              hit
);
    always_comb begin
        hit     = (orig == opa);
        wr_en   = 1'b0;
        wr_data = orig;
        unique case (op)
            OP_XCHG: begin
                wr_en   = 1'b1;
                wr_data = opa;
            end
            OP_CXCHG: begin
                wr_en   = hit;
                wr_data = opb;
            end
            OP_FADD: begin
                wr_en   = 1'b1;
                wr_data = orig + opa;
            end
            default: begin
                wr_en   = 1'b0;
                wr_data = orig;
            end
        endcase
    end
endmodule

// File: rtl/atom_ctrl.sv
module atom_ctrl
    import atom_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [OP_W-1:0]   req_op,
    input  logic [DATA_W-1:0] req_opa,
    input  logic [DATA_W-1:0] req_opb,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_data,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic              rsp_err,
    output logic              rsp_match,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [OP_W-1:0]   alu_op,
    output logic [DATA_W-1:0] alu_opa,
    output logic [DATA_W-1:0] alu_opb,
    input  logic              alu_we,
    input  logic [DATA_W-1:0] alu_wdata,
    input  logic              alu_hit
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [OP_W-1:0]   op;
        logic [DATA_W-1:0] opa;
        logic [DATA_W-1:0] opb;
        logic [TAG_W-1:0]  tag;
    } held_t;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [TAG_W-1:0]  tag;
        logic              err;
        logic              match;
    } reply_t;

    phase_e phase;
    held_t  held;
    reply_t reply;
    logic   accept;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;
    assign rsp_valid = (phase == PH_RESP);
    assign rsp_data  = reply.data;
    assign rsp_tag   = reply.tag;
    assign rsp_err   = reply.err;
    assign rsp_match = reply.match;

    assign alu_op    = held.op;
    assign alu_opa   = held.opa;
    assign alu_opb   = held.opb;

    assign mem_we    = (phase == PH_MODIFY) && alu_we;
    assign mem_en    = (accept && op_needs_mem(req_op)) || mem_we;
    assign mem_addr  = (phase == PH_IDLE) ? req_addr : held.addr;
    assign mem_wdata = alu_wdata;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            held  <= '0;
            reply <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        held <= '{addr: req_addr, op: req_op, opa: req_opa,
                                  opb: req_opb, tag: req_tag};
                        if (op_needs_mem(req_op)) begin
                            phase <= PH_MODIFY;
                        end else begin
                            phase <= PH_RESP;
                            reply <= '{data: '0, tag: req_tag,
                                       err: op_reserved(req_op), match: 1'b0};
                        end
                    end
                end
                PH_MODIFY: begin
                    phase <= PH_RESP;
                    reply <= '{data: mem_rdata, tag: held.tag, err: 1'b0,
                               match: (held.op == OP_CXCHG) && alu_hit};
                end
                PH_RESP: begin
                    if (rsp_ready) begin
                        phase <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R1: an accepted request closes the request channel on the next cycle
    p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (rst)
        accept |=> !req_ready);

    // R10: an unclaimed response does not move
    p_rsp_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) &&
            $stable(rsp_tag) && $stable(rsp_err) && $stable(rsp_match)));

    // R7: a reserved-code reply carries no data and no match
    p_err_reply_r7: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_data == '0 && !rsp_match));
endmodule

// File: rtl/atomic_responder.sv
module atomic_responder
    import atom_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [2:0]        req_op,
    input  logic [DATA_W-1:0] req_opa,
    input  logic [DATA_W-1:0] req_opb,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_data,
    output logic [TAG_W-1:0]  rsp_tag,
    output logic              rsp_err,
    output logic              rsp_match
);
    logic              mem_en;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;
    logic [OP_W-1:0]   alu_op;
    logic [DATA_W-1:0] alu_opa;
    logic [DATA_W-1:0] alu_opb;
    logic              alu_we;
    logic [DATA_W-1:0] alu_wdata;
    logic              alu_hit;

    atom_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_addr  (req_addr),
        .req_op    (req_op),
        .req_opa   (req_opa),
        .req_opb   (req_opb),
        .req_tag   (req_tag),
        .rsp_valid (rsp_valid),
        .rsp_ready (rsp_ready),
        .rsp_data  (rsp_data),
        .rsp_tag   (rsp_tag),
        .rsp_err   (rsp_err),
        .rsp_match (rsp_match),
        .mem_en    (mem_en),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .alu_op    (alu_op),
        .alu_opa   (alu_opa),
        .alu_opb   (alu_opb),
        .alu_we    (alu_we),
        .alu_wdata (alu_wdata),
        .alu_hit   (alu_hit)
    );

    atom_alu #(.DATA_W(DATA_W)) alu_i (
        .op      (alu_op),
        .orig    (mem_rdata),
        .opa     (alu_opa),
        .opb     (alu_opb),
        .wr_en   (alu_we),
        .wr_data (alu_wdata),
        .hit     (alu_hit)
    );

    atom_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) mem_i (
        .clk   (clk),
        .en    (mem_en),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (mem_rdata)
    );

    // R9: every write is preceded, one cycle earlier, by a read of the same word
    p_write_follows_read_r9: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> ($past(mem_en && !mem_we) && $past(mem_addr) == mem_addr));

    // R9: no second read may slip in right after a read
    p_no_back_to_back_read_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_en && !mem_we) |=> !(mem_en && !mem_we));

    // R1: memory stays quiet while a response waits
    p_quiet_while_resp_r1: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !mem_en);
endmodule

// File: tb/atomic_responder_tb.sv
module atomic_responder_tb_top;
    localparam int AW = 6;
    localparam int DW = 32;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [2:0]    req_op = '0;
    logic [DW-1:0] req_opa = '0;
    logic [DW-1:0] req_opb = '0;
    logic [TW-1:0] req_tag = '0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b1;
    logic [DW-1:0] rsp_data;
    logic [TW-1:0] rsp_tag;
    logic          rsp_err;
    logic          rsp_match;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    atomic_responder #(.ADDR_W(AW), .DATA_W(DW), .TAG_W(TW)) dut_i (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_op(req_op), .req_opa(req_opa), .req_opb(req_opb), .req_tag(req_tag),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .rsp_tag(rsp_tag), .rsp_err(rsp_err), .rsp_match(rsp_match)
    );

    typedef struct packed {
        logic [2:0]    op;
        logic [AW-1:0] addr;
        logic [DW-1:0] a;
        logic [DW-1:0] b;
        logic [TW-1:0] tag;
        logic          chk;
        logic [DW-1:0] exp;
        logic          err;
        logic          hit;
    } vec_t;

    // op: 0 probe, 1 exchange, 2 compare-exchange, 3 fetch-add, 4..7 reserved
    localparam vec_t VECS [15] = '{
        '{3'd1, 6'd5, 32'h1111_1111, 32'h0, 4'd1,  1'b0, 32'h0,         1'b0, 1'b0},
        '{3'd1, 6'd5, 32'h2222_2222, 32'h0, 4'd2,  1'b1, 32'h1111_1111, 1'b0, 1'b0},
        '{3'd3, 6'd5, 32'h0000_0010, 32'h0, 4'd3,  1'b1, 32'h2222_2222, 1'b0, 1'b0},
        '{3'd0, 6'd5, 32'h9999_9999, 32'h0, 4'd4,  1'b1, 32'h0,         1'b0, 1'b0},
        '{3'd1, 6'd5, 32'h0,         32'h0, 4'd5,  1'b1, 32'h2222_2232, 1'b0, 1'b0},
        '{3'd1, 6'd9, 32'hFFFF_FFFF, 32'h0, 4'd6,  1'b0, 32'h0,         1'b0, 1'b0},
        '{3'd3, 6'd9, 32'h0000_0002, 32'h0, 4'd7,  1'b1, 32'hFFFF_FFFF, 1'b0, 1'b0},
        '{3'd1, 6'd9, 32'h0,         32'h0, 4'd8,  1'b1, 32'h0000_0001, 1'b0, 1'b0},
        '{3'd2, 6'd5, 32'h0, 32'hABCD_0000, 4'd9,  1'b1, 32'h0,         1'b0, 1'b1},
        '{3'd2, 6'd5, 32'h0, 32'h1234_5678, 4'd10, 1'b1, 32'hABCD_0000, 1'b0, 1'b0},
        '{3'd4, 6'd5, 32'h55, 32'h55,       4'd11, 1'b1, 32'h0,         1'b1, 1'b0},
        '{3'd7, 6'd5, 32'h66, 32'h66,       4'd12, 1'b1, 32'h0,         1'b1, 1'b0},
        '{3'd1, 6'd5, 32'h7,         32'h0, 4'd13, 1'b1, 32'hABCD_0000, 1'b0, 1'b0},
        '{3'd2, 6'd5, 32'h7, 32'h0000_00AA, 4'd14, 1'b1, 32'h0000_0007, 1'b0, 1'b1},
        '{3'd1, 6'd5, 32'h0,         32'h0, 4'd15, 1'b1, 32'h0000_00AA, 1'b0, 1'b0}
    };

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_vec(input vec_t v, input string name);
        int lat;
        int exp_lat;
        exp_lat = (v.op == 3'd1 || v.op == 3'd2 || v.op == 3'd3) ? 2 : 1;
        @(negedge clk);
        req_addr = v.addr; req_op = v.op; req_opa = v.a; req_opb = v.b;
        req_tag = v.tag; req_valid = 1'b1; rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 8) begin
            @(negedge clk);
            lat++;
        end
        check({"R11 latency ", name}, DW'(lat), DW'(exp_lat));
        check({"R1 busy ", name}, DW'(req_ready), DW'(0));
        if (v.chk) check({"R3/R4/R5/R6 data ", name}, rsp_data, v.exp);
        check({"R7 err ", name}, DW'(rsp_err), DW'(v.err));
        check({"R5 R8 match ", name}, DW'(rsp_match), DW'(v.hit));
        check({"R8 tag ", name}, DW'(rsp_tag), DW'(v.tag));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 R12-like reset state
        check("R1 reset req_ready", DW'(req_ready), DW'(1));
        check("R1 reset rsp_valid", DW'(rsp_valid), DW'(0));

        // table walk: R2 R3 R4 R5 R6 R7 R8 R11
        for (int i = 0; i < 15; i++) begin
            run_vec(VECS[i], $sformatf("vec%0d", i));
        end

        // R10 / R1: held response and refused intruder
        // addr 9 holds 0 after vec7
        @(negedge clk);
        req_addr = 6'd9; req_op = 3'd1; req_opa = 32'hCAFE_0000;
        req_tag = 4'd3; req_valid = 1'b1; rsp_ready = 1'b0;
        @(negedge clk);
        req_opa = 32'hDEAD_BEEF; req_tag = 4'd6;
        @(negedge clk);
        check("R11 bp latency", DW'(rsp_valid), DW'(1));
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R10 held valid", DW'(rsp_valid), DW'(1));
            check("R10 held data", rsp_data, 32'h0);
            check("R10 held tag", DW'(rsp_tag), DW'(3));
            check("R1 refused while busy", DW'(req_ready), DW'(0));
        end
        req_valid = 1'b0;
        rsp_ready = 1'b1;
        @(negedge clk);
        check("R10 release", DW'(rsp_valid), DW'(0));
        check("R1 ready again", DW'(req_ready), DW'(1));
        run_vec('{3'd1, 6'd9, 32'h0, 32'h0, 4'd2, 1'b1, 32'hCAFE_0000, 1'b0, 1'b0},
                "R1 intruder ignored");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule